// File: doc/BRIEF.md
# Ping-Pong Bitonic Sort Sequencer

This block sorts a set of N = W*H unsigned keys held in a two-dimensional memory image, ascending. Element (x, y) sits at linear address y*W + x. The sequencer walks the sorting network one stage and one step at a time. Each compare-exchange uses the element's own key and one partner key.

The block works with two buffers, A and B. Each buffer is a synchronous RAM with two read ports and one write port. In every step the block reads the whole array from the source buffer and writes each result to the same address in the other buffer. The two buffers swap roles after every step. The keys must be loaded into buffer A before the block is started.

A one-cycle `start` pulse launches a sort. A one-cycle `done` pulse ends it, together with a flag that names the buffer holding the sorted keys. There is no streaming data interface. The control pins and the RAM pins are plain signals without back-pressure, because the RAMs answer every read one cycle after it is issued.

The parameters W, H and TILE_H must be powers of two, with TILE_H <= H and N >= 2. KEY_W sets the key width. DUAL_READ selects how the two reads of an element are issued, as described in R6.

Top module: `bitonic_seq`

## Requirements
- R1: Element (x, y) of the image is stored at RAM address y*W + x, and the sequencer addresses every element through that linear index k.
- R2: In each step, every address 0..N-1 is written exactly once, into the destination buffer only. The first step reads A and writes B. The buffers then swap after every step. No buffer is ever read and written in the same cycle, and the two write enables are never high together.
- R3: The steps follow this order: stages i = 1..log2(N), and within stage i, steps j = i down to 1. On the first step of a stage (j = i), the partner of k is k XOR (2^i - 1), which is the mirrored element in its block of 2^i. On every other step, the partner is k XOR 2^(j-1).
- R4: The mask bit of element k in step j is bit (j-1) of k. A mask of 0 writes min(own, partner) to address k. A mask of 1 writes max(own, partner) to address k.
- R5: Let d = 2^(j-1) be the compare distance. When d < W, elements are visited in tiled order. Counting from outermost to innermost, the loops are: band of TILE_H rows, then column strip of width d, then row inside the band, then column inside the strip. When d >= W, elements are visited in plain ascending k.
- R6: The RAMs return read data one cycle after a read is enabled. With DUAL_READ = 1, the own address is issued on read port 0 and the partner address on read port 1 in the same cycle, so one element is handled per cycle. With DUAL_READ = 0, port 0 reads the own key in one cycle and the partner key in the next, so one element is handled every two cycles. In both modes the write lands one cycle after the last read of that element.
- R7: `busy` is high from the clock edge that accepts `start` until `done`. `done` is a single-cycle pulse. It goes high S*(N*C+1) cycles after the accepting edge, where S = L(L+1)/2, L = log2(N), and C = 1 or 2 as set by R6. The extra cycle in each step drains the last write.
- R8: With `done`, `result_in_b` is 1 when S is odd (the result is in B) and 0 when S is even (the result is in A). The named buffer then holds the input keys in ascending order.
- R9: A `start` pulse while `busy` is high is ignored. The write sequence, the completion time and the result stay unchanged.
- R10: While reset is asserted, and when idle after reset, `busy`, `done` and all read enables and write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a sort (ignored while busy) |
| busy | output | 1 | Sort in progress |
| done | output | 1 | One-cycle completion pulse |
| result_in_b | output | 1 | Sorted keys are in buffer B (valid with done) |
| a_re | output | 1 | Buffer A read enable (both read ports) |
| a_raddr0 | output | log2(W*H) | Buffer A read port 0 address |
| a_raddr1 | output | log2(W*H) | Buffer A read port 1 address |
| a_rdata0 | input | KEY_W | Buffer A read port 0 data, one cycle after a_re |
| a_rdata1 | input | KEY_W | Buffer A read port 1 data, one cycle after a_re |
| a_we | output | 1 | Buffer A write enable |
| a_waddr | output | log2(W*H) | Buffer A write address |
| a_wdata | output | KEY_W | Buffer A write data |
| b_re | output | 1 | Buffer B read enable (both read ports) |
| b_raddr0 | output | log2(W*H) | Buffer B read port 0 address |
| b_raddr1 | output | log2(W*H) | Buffer B read port 1 address |
| b_rdata0 | input | KEY_W | Buffer B read port 0 data |
| b_rdata1 | input | KEY_W | Buffer B read port 1 data |
| b_we | output | 1 | Buffer B write enable |
| b_waddr | output | log2(W*H) | Buffer B write address |
| b_wdata | output | KEY_W | Buffer B write data |

## Verification
Each result write arrives one cycle after the last read of its element. Both the single-port and the dual-read instance therefore produce the same ordered write stream, at one or two cycles per element. The scoreboard does not count cycles for individual writes. Instead it compares each write, in order, against the (buffer, address, key) sequence built from a bench model of the network. The `done` pulse is checked against its exact cycle, S*(N*C+1) edges after the accepting edge, and is sampled at the falling edge. The sorted buffer is read back only after `done`.

// File: rtl/bsort_pkg.sv
package bsort_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_DRAIN} sq_state_e;
endpackage

// File: rtl/bsort_sched.sv
// Stage/step walker of the sorting network.
module bsort_sched #(
  parameter int LN = 5,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          adv,
  output logic [SW-1:0] stg,
  output logic [SW-1:0] stp,
  output logic          first,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      stg <= SW'(1);
      stp <= SW'(1);
    end else if (adv) begin
      if (stp == SW'(1)) begin
        stg <= stg + SW'(1);
        stp <= stg + SW'(1);
      end else begin
        stp <= stp - SW'(1);
      end
    end
  end

  assign first = (stp == stg);
  assign last  = (stp == SW'(1)) && (stg == SW'(LN));
endmodule

// File: rtl/bsort_addr.sv
// Maps the visit counter to the element index (tiled when the distance is
// below the row width), then derives the partner index and the mask bit.
module bsort_addr #(
  parameter int LW  = 3,
  parameter int LH  = 2,
  parameter int LTH = 1,
  parameter int SW  = 3,
  parameter int AW  = LW + LH
) (
  input  logic [AW-1:0] t,
  input  logic [SW-1:0] stg,
  input  logic [SW-1:0] stp,
  input  logic          first,
  output logic [AW-1:0] k,
  output logic [AW-1:0] p,
  output logic          mask
);
  localparam logic [AW-1:0] ONE   = AW'(1);
  localparam logic [AW-1:0] TMASK = (ONE << LTH) - ONE;

  logic [SW-1:0] lg;
  logic [AW-1:0] hop;

  assign lg = stp - SW'(1);

  always_comb begin
    if (lg < SW'(LW)) begin
      k = ((t >> (LW + LTH)) << (LW + LTH))
        | (((t >> lg) & TMASK) << LW)
        | (((t >> (lg + LTH)) & ((ONE << (LW - lg)) - ONE)) << lg)
        | (t & ((ONE << lg) - ONE));
    end else begin
      k = t;
    end
    hop  = first ? ((ONE << stg) - ONE) : (ONE << lg);
    p    = k ^ hop;
    mask = k[lg];
  end
endmodule

// File: rtl/bsort_lane.sv
// One compare-exchange lane: issues the two reads, then writes min or max.
module bsort_lane #(
  parameter int KW   = 8,
  parameter int AW   = 5,
  parameter bit DUAL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          src_b,
  input  logic [AW-1:0] k,
  input  logic [AW-1:0] p,
  input  logic          mask,
  input  logic [KW-1:0] rd0,
  input  logic [KW-1:0] rd1,
  output logic          re,
  output logic [AW-1:0] ra0,
  output logic [AW-1:0] ra1,
  output logic          elem_ok,
  output logic          wv,
  output logic [AW-1:0] wa,
  output logic [KW-1:0] wd,
  output logic          wb
);
  logic          wm;
  logic [KW-1:0] own, par;

  assign re  = go;
  assign ra1 = p;

  generate
    if (DUAL) begin : g_dual
      assign ra0     = k;
      assign elem_ok = go;
      assign own     = rd0;
      assign par     = rd1;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          wv <= 1'b0; wa <= '0; wm <= 1'b0; wb <= 1'b0;
        end else begin
          wv <= go;
          if (go) begin
            wa <= k; wm <= mask; wb <= ~src_b;
          end
        end
      end
    end else begin : g_serial
      logic          ph;
      logic [KW-1:0] own_q;
      logic          unused_rd1;
      assign unused_rd1 = ^rd1;
      assign ra0     = ph ? p : k;
      assign elem_ok = go && ph;
      assign own     = own_q;
      assign par     = rd0;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ph <= 1'b0; wv <= 1'b0; wa <= '0; wm <= 1'b0; wb <= 1'b0; own_q <= '0;
        end else begin
          ph <= go ? ~ph : 1'b0;
          wv <= go && ph;
          if (go && ph) begin
            wa <= k; wm <= mask; wb <= ~src_b; own_q <= rd0;
          end
        end
      end
    end
  endgenerate

  assign wd = wm ? ((own > par) ? own : par) : ((own > par) ? par : own);
endmodule

// File: rtl/bitonic_seq.sv
module bitonic_seq #(
  parameter int W         = 8,
  parameter int H         = 4,
  parameter int TILE_H    = 2,
  parameter int KEY_W     = 8,
  parameter bit DUAL_READ = 1'b1,
  parameter int AW        = $clog2(W * H)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             result_in_b,
  output logic             a_re,
  output logic [AW-1:0]    a_raddr0,
  output logic [AW-1:0]    a_raddr1,
  input  logic [KEY_W-1:0] a_rdata0,
  input  logic [KEY_W-1:0] a_rdata1,
  output logic             a_we,
  output logic [AW-1:0]    a_waddr,
  output logic [KEY_W-1:0] a_wdata,
  output logic             b_re,
  output logic [AW-1:0]    b_raddr0,
  output logic [AW-1:0]    b_raddr1,
  input  logic [KEY_W-1:0] b_rdata0,
  input  logic [KEY_W-1:0] b_rdata1,
  output logic             b_we,
  output logic [AW-1:0]    b_waddr,
  output logic [KEY_W-1:0] b_wdata
);
  import bsort_pkg::*;

  localparam int LW  = $clog2(W);
  localparam int LH  = $clog2(H);
  localparam int LTH = $clog2(TILE_H);
  localparam int N   = W * H;
  localparam int SW  = $clog2(LW + LH + 1);

  sq_state_e         state;
  logic [AW-1:0]     t;
  logic              src_b, done_q, resb_q, go;
  logic [SW-1:0]     stg, stp;
  logic              first, last;
  logic [AW-1:0]     k, p, ra0, ra1, wa;
  logic              mask, re, elem_ok, wv, wb;
  logic [KEY_W-1:0]  rd0, rd1, wd;

  assign go = (state == SQ_RUN);

  bsort_sched #(.LN(LW + LH), .SW(SW)) u_sched (
    .clk(clk), .rst_n(rst_n),
    .init((state == SQ_IDLE) && start),
    .adv((state == SQ_DRAIN) && !last),
    .stg(stg), .stp(stp), .first(first), .last(last)
  );

  bsort_addr #(.LW(LW), .LH(LH), .LTH(LTH), .SW(SW), .AW(AW)) u_addr (
    .t(t), .stg(stg), .stp(stp), .first(first), .k(k), .p(p), .mask(mask)
  );

  assign rd0 = src_b ? b_rdata0 : a_rdata0;
  assign rd1 = src_b ? b_rdata1 : a_rdata1;

  bsort_lane #(.KW(KEY_W), .AW(AW), .DUAL(DUAL_READ)) u_lane (
    .clk(clk), .rst_n(rst_n), .go(go), .src_b(src_b),
    .k(k), .p(p), .mask(mask), .rd0(rd0), .rd1(rd1),
    .re(re), .ra0(ra0), .ra1(ra1), .elem_ok(elem_ok),
    .wv(wv), .wa(wa), .wd(wd), .wb(wb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      t      <= '0;
      src_b  <= 1'b0;
      done_q <= 1'b0;
      resb_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        SQ_IDLE: if (start) begin
          state <= SQ_RUN;
          t     <= '0;
          src_b <= 1'b0;
        end
        SQ_RUN: if (elem_ok) begin
          if (t == AW'(N - 1)) state <= SQ_DRAIN;
          else                 t     <= t + AW'(1);
        end
        SQ_DRAIN: begin
          src_b <= ~src_b;
          t     <= '0;
          if (last) begin
            state  <= SQ_IDLE;
            done_q <= 1'b1;
            resb_q <= ~src_b;
          end else begin
            state <= SQ_RUN;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy        = (state != SQ_IDLE);
  assign done        = done_q;
  assign result_in_b = resb_q;

  assign a_re     = re && !src_b;
  assign b_re     = re && src_b;
  assign a_raddr0 = ra0;
  assign a_raddr1 = ra1;
  assign b_raddr0 = ra0;
  assign b_raddr1 = ra1;
  assign a_we     = wv && !wb;
  assign b_we     = wv && wb;
  assign a_waddr  = wa;
  assign b_waddr  = wa;
  assign a_wdata  = wd;
  assign b_wdata  = wd;
endmodule

// File: rtl/bsort_chk.sv
module bsort_chk #(
  parameter int AW = 5
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic result_in_b,
  input logic a_re,
  input logic a_we,
  input logic b_re,
  input logic b_we
);
  localparam int  NSTEP = AW * (AW + 1) / 2;
  localparam bit  RES_B = (NSTEP % 2) == 1;

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_we && b_we)); // R2
  AST_NO_RW_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_re && a_we) && !(b_re && b_we)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R7
  AST_RES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result_in_b == RES_B)); // R8
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(a_re || b_re || a_we || b_we)); // R10
endmodule

bind bitonic_seq bsort_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .result_in_b(result_in_b), .a_re(a_re), .a_we(a_we), .b_re(b_re), .b_we(b_we)
);

// File: tb/bitonic_seq_tb_top.sv
module bsort_tb_ram #(
  parameter int KW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          re,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [KW-1:0] rd0,
  output logic [KW-1:0] rd1,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [KW-1:0] wd
);
  logic [KW-1:0] mem [2**AW];
  always @(posedge clk) begin
    if (re) begin
      rd0 <= mem[ra0];
      rd1 <= mem[ra1];
    end
    if (we) mem[wa] <= wd;
  end
endmodule

module bitonic_seq_tb_top;
  localparam int W = 8, H = 4, TH = 2, KW = 8;
  localparam int N = W * H;
  localparam int AW = $clog2(N);
  localparam int S = AW * (AW + 1) / 2;

  typedef struct packed {
    logic          b;
    logic [AW-1:0] a;
    logic [KW-1:0] d;
  } wr_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  wr_t q0[$], q1[$];

  // two instances: dual-read (d_) and single-port (s_)
  logic d_busy, d_done, d_resb, d_are, d_awe, d_bre, d_bwe;
  logic [AW-1:0] d_ara0, d_ara1, d_awa, d_bra0, d_bra1, d_bwa;
  logic [KW-1:0] d_ard0, d_ard1, d_awd, d_brd0, d_brd1, d_bwd;
  logic s_busy, s_done, s_resb, s_are, s_awe, s_bre, s_bwe;
  logic [AW-1:0] s_ara0, s_ara1, s_awa, s_bra0, s_bra1, s_bwa;
  logic [KW-1:0] s_ard0, s_ard1, s_awd, s_brd0, s_brd1, s_bwd;

  bitonic_seq #(.W(W), .H(H), .TILE_H(TH), .KEY_W(KW), .DUAL_READ(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(d_busy), .done(d_done),
    .result_in_b(d_resb),
    .a_re(d_are), .a_raddr0(d_ara0), .a_raddr1(d_ara1), .a_rdata0(d_ard0),
    .a_rdata1(d_ard1), .a_we(d_awe), .a_waddr(d_awa), .a_wdata(d_awd),
    .b_re(d_bre), .b_raddr0(d_bra0), .b_raddr1(d_bra1), .b_rdata0(d_brd0),
    .b_rdata1(d_brd1), .b_we(d_bwe), .b_waddr(d_bwa), .b_wdata(d_bwd));

  bitonic_seq #(.W(W), .H(H), .TILE_H(TH), .KEY_W(KW), .DUAL_READ(1'b0)) dut_s_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(s_busy), .done(s_done),
    .result_in_b(s_resb),
    .a_re(s_are), .a_raddr0(s_ara0), .a_raddr1(s_ara1), .a_rdata0(s_ard0),
    .a_rdata1(s_ard1), .a_we(s_awe), .a_waddr(s_awa), .a_wdata(s_awd),
    .b_re(s_bre), .b_raddr0(s_bra0), .b_raddr1(s_bra1), .b_rdata0(s_brd0),
    .b_rdata1(s_brd1), .b_we(s_bwe), .b_waddr(s_bwa), .b_wdata(s_bwd));

  bsort_tb_ram #(.KW(KW), .AW(AW)) ram_da (.clk(clk), .re(d_are), .ra0(d_ara0),
    .ra1(d_ara1), .rd0(d_ard0), .rd1(d_ard1), .we(d_awe), .wa(d_awa), .wd(d_awd));
  bsort_tb_ram #(.KW(KW), .AW(AW)) ram_db (.clk(clk), .re(d_bre), .ra0(d_bra0),
    .ra1(d_bra1), .rd0(d_brd0), .rd1(d_brd1), .we(d_bwe), .wa(d_bwa), .wd(d_bwd));
  bsort_tb_ram #(.KW(KW), .AW(AW)) ram_sa (.clk(clk), .re(s_are), .ra0(s_ara0),
    .ra1(s_ara1), .rd0(s_ard0), .rd1(s_ard1), .we(s_awe), .wa(s_awa), .wd(s_awd));
  bsort_tb_ram #(.KW(KW), .AW(AW)) ram_sb (.clk(clk), .re(s_bre), .ra0(s_bra0),
    .ra1(s_bra1), .rd0(s_brd0), .rd1(s_brd1), .we(s_bwe), .wa(s_bwa), .wd(s_bwd));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitors: compare every write against the scoreboard, in order (R2 R3 R4 R5 R6)
  int  d_done_cyc, s_done_cyc;
  bit  d_seen, s_seen, d_flag, s_flag;
  always @(negedge clk) begin
    if (rst_n && (d_awe || d_bwe)) begin
      wr_t g, e;
      g = '{b: d_bwe, a: (d_bwe ? d_bwa : d_awa), d: (d_bwe ? d_bwd : d_awd)};
      if (q0.size() == 0) chk(1'b0, "R2 dual extra write", longint'(g), 0);
      else begin
        e = q0.pop_front();
        chk(g == e, "R3 R4 R5 dual write", longint'(g), longint'(e));
      end
    end
    if (rst_n && (s_awe || s_bwe)) begin
      wr_t g, e;
      g = '{b: s_bwe, a: (s_bwe ? s_bwa : s_awa), d: (s_bwe ? s_bwd : s_awd)};
      if (q1.size() == 0) chk(1'b0, "R2 serial extra write", longint'(g), 0);
      else begin
        e = q1.pop_front();
        chk(g == e, "R6 serial write", longint'(g), longint'(e));
      end
    end
    if (d_done && !d_seen) begin d_seen = 1; d_done_cyc = cyc; d_flag = d_resb; end
    if (s_done && !s_seen) begin s_seen = 1; s_done_cyc = cyc; s_flag = s_resb; end
  end

  // driver: builds the expected write stream from the network definition
  task automatic push_expected(input int data[N]);
    int cur[N], nxt[N];
    bit src = 0;
    cur = data;
    for (int i = 1; i <= AW; i++) begin
      for (int j = i; j >= 1; j--) begin
        int d = 1 << (j - 1);
        int order[N];
        int n = 0;
        if (d < W) begin
          for (int b = 0; b < H / TH; b++)
            for (int s = 0; s < W / d; s++)
              for (int r = 0; r < TH; r++)
                for (int c = 0; c < d; c++) begin
                  order[n] = (b * TH + r) * W + s * d + c;
                  n++;
                end
        end else begin
          for (int kk = 0; kk < N; kk++) order[kk] = kk;
        end
        for (int v = 0; v < N; v++) begin
          int kk = order[v];
          int off = kk % (1 << i);
          int pp = (j == i) ? (kk - off + ((1 << i) - 1 - off)) : (((kk / d) % 2) ? kk - d : kk + d);
          bit mx = (j == i) ? (off >= (1 << (i - 1))) : ((kk / d) % 2 == 1);
          int lo = (cur[kk] < cur[pp]) ? cur[kk] : cur[pp];
          int hi = (cur[kk] < cur[pp]) ? cur[pp] : cur[kk];
          wr_t e;
          e = '{b: ~src, a: AW'(kk), d: KW'(mx ? hi : lo)};
          nxt[kk] = mx ? hi : lo;
          q0.push_back(e);
          q1.push_back(e);
        end
        cur = nxt;
        src = ~src;
      end
    end
  endtask

  bit aborted = 0;

  task automatic run_sort(input int pat, input bit poke);
    int data[N], ref_s[N];
    int t0, guard;
    for (int i = 0; i < N; i++) begin
      case (pat)
        0: data[i] = (i * 73 + 29) % 251;
        1: data[i] = 250 - i * 7;
        default: data[i] = (i % 3) * 40;
      endcase
      ram_da.mem[i] = KW'(data[i]);
      ram_sa.mem[i] = KW'(data[i]);
    end
    ref_s = data;
    for (int i = 1; i < N; i++)
      for (int j = i; j > 0 && ref_s[j-1] > ref_s[j]; j--) begin
        int tmp = ref_s[j]; ref_s[j] = ref_s[j-1]; ref_s[j-1] = tmp;
      end
    push_expected(data);
    d_seen = 0; s_seen = 0;
    @(negedge clk);
    start = 1'b1;
    t0 = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    chk(d_busy && s_busy, "R7 busy after start", {d_busy, s_busy}, 3);
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(d_busy && s_busy, "R9 busy kept after extra start", {d_busy, s_busy}, 3);
    end
    guard = 0;
    while (!(d_seen && s_seen) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    if (!(d_seen && s_seen)) begin
      chk(1'b0, "R7 watchdog expired", guard, 0);
      aborted = 1;
      return;
    end
    @(negedge clk);
    chk(!s_done && !d_done, "R7 done single pulse", {d_done, s_done}, 0);
    chk(d_done_cyc == t0 + S * (N + 1), "R7 dual done cycle", d_done_cyc - t0, S * (N + 1));
    chk(s_done_cyc == t0 + S * (2 * N + 1), "R7 serial done cycle", s_done_cyc - t0, S * (2 * N + 1));
    chk(d_flag == (S % 2 == 1), "R8 dual result flag", d_flag, S % 2);
    chk(s_flag == (S % 2 == 1), "R8 serial result flag", s_flag, S % 2);
    chk(!d_busy && !s_busy, "R7 busy low after done", {d_busy, s_busy}, 0);
    chk(q0.size() == 0 && q1.size() == 0, "R2 all writes seen", q0.size() + q1.size(), 0);
    for (int i = 0; i < N; i++) begin
      logic [KW-1:0] dv, sv;
      dv = (S % 2 == 1) ? ram_db.mem[i] : ram_da.mem[i];
      sv = (S % 2 == 1) ? ram_sb.mem[i] : ram_sa.mem[i];
      chk(dv == KW'(ref_s[i]) && sv == KW'(ref_s[i]), "R8 R1 sorted key", {dv, sv}, ref_s[i]);
    end
    q0.delete();
    q1.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!d_busy && !d_done && !d_are && !d_bre && !d_awe && !d_bwe, "R10 reset dual",
        {d_busy, d_done, d_are, d_bre, d_awe, d_bwe}, 0);
    chk(!s_busy && !s_done && !s_are && !s_bre && !s_awe && !s_bwe, "R10 reset serial",
        {s_busy, s_done, s_are, s_bre, s_awe, s_bwe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!d_busy && !s_busy && !d_are && !s_are, "R10 idle after reset", {d_busy, s_busy}, 0);
    run_sort(0, 1'b0);
    if (!aborted) run_sort(1, 1'b1);
    if (!aborted) run_sort(2, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule